// File: doc/BRIEF.md
# Programmable Register Update Clock Generator

This block produces the transfer strobe that copies staged programming registers into the active core of a signal generator. The strobe has two possible sources. In internal mode a reloadable down-counter advances once every two system clocks and fires a strobe each time it passes zero, so transfers happen at a fixed, programmable rate. In external mode an asynchronous rising edge on an input line is brought into the clock domain and becomes a single-cycle strobe. Because every transfer is tied to the system clock, register data is never moved partly old and partly new.

The block also drives a shared update pin. In this design the pin is split into an output value, an output enable and an input. In internal mode the pin is driven, and each strobe is shown on it as a high pulse of fixed length. When the reload value is very small, the pin is held high for as long as that value is in effect. In external mode the pin is released and its input side is the edge source.

A change of the reload value takes effect at the next reload. Switching modes restarts the counter and cancels any pin pulse that is in progress.

Top module: `upd_clk_gen`

## Requirements
- R1: `mode_int` high selects internal generation and low selects external edges. After a synchronous reset the block is in internal mode, so `pin_oe` is 1 and `upd_strobe` is 0.
- R2: In internal mode with reload value N (N >= 1), consecutive `upd_strobe` pulses are exactly 2*(N+1) system clock cycles apart.
- R3: After reset is released in internal mode, the first `upd_strobe` is high in the sample that follows the 2*(N+1)-th rising clock edge. Each strobe is high for exactly one cycle.
- R4: A new value on `reload_val` does not shorten or lengthen the period already running. The interval that starts at the next strobe uses the new value.
- R5: In internal mode with N >= 5, `pin_out` goes high in the same cycle as `upd_strobe` and stays high for exactly 8 cycles.
- R6: In internal mode with an active N below 5, `pin_out` is continuously 1, and `upd_strobe` keeps its 2*(N+1) spacing.
- R7: In external mode a 0-to-1 transition on `ext_in` gives one `upd_strobe` that is one cycle wide. It appears in the sample after the third rising clock edge that follows the change.
- R8: In external mode a falling edge on `ext_in`, a level held high, or a steady low produces no `upd_strobe`. The internal counter never causes a strobe in this mode.
- R9: `pin_oe` is 1 only in internal mode. In external mode `pin_out` is 0.
- R10: A change of `mode_int` clears any pin pulse in progress within one clock. When the block enters internal mode, the count restarts from N, so the first strobe comes 2*(N+1)+1 rising edges after the input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_int | input | 1 | 1 = internal periodic source, 0 = external edge source |
| reload_val | input | 32 | Reload value N for the down-counter |
| ext_in | input | 1 | Input side of the update pin (asynchronous) |
| upd_strobe | output | 1 | One-cycle transfer strobe to the register file |
| pin_out | output | 1 | Output value of the update pin |
| pin_oe | output | 1 | Output enable of the update pin |

## Verification
The assertions assume three things about the inputs. In internal mode `reload_val` stays at 1 or more. `ext_in` has already settled low when external mode is entered. Each level on `ext_in` lasts at least two clock cycles, so the synchronizer sees every edge. The stimulus keeps to these limits: reload values are drawn from a bounded range starting at 1, and every external high and low phase is held for a random 4 to 10 cycles. A few directed cases cover the limit at N = 4 and N = 5, a mode switch in the middle of a pin pulse, and a level held high for a long time.

// File: rtl/upd_pkg.sv
package upd_pkg;

    typedef enum logic {
        UPD_SRC_EXT = 1'b0,
        UPD_SRC_INT = 1'b1
    } upd_src_e;

    // Events from the internal countdown path for one cycle
    typedef struct packed {
        logic fire;       // counter passes zero on this tick
        logic hold_high;  // active reload value is below the pin limit
    } int_evt_t;

    localparam int unsigned UPD_PULSE_CYCLES = 8;
    localparam int unsigned UPD_SMALL_LIMIT  = 5;

    function automatic logic below_limit(input logic [63:0] n, input int unsigned lim);
        return n < 64'(lim);
    endfunction

endpackage

// File: rtl/upd_cnt_core.sv
module upd_cnt_core
    import upd_pkg::*;
#(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned SMALL_LIM = UPD_SMALL_LIMIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] reload_val,
    output int_evt_t         evt
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic             phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] active_n_q;
    logic             tick;
    logic             at_zero;

    assign tick    = run && phase_q;
    assign at_zero = (cnt_q == CNT_ZERO);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q    <= 1'b0;
            cnt_q      <= reload_val;
            active_n_q <= reload_val;
        end else if (run) begin
            phase_q <= ~phase_q;
            if (phase_q) begin
                if (at_zero) begin
                    cnt_q      <= reload_val;
                    active_n_q <= reload_val;
                end else begin
                    cnt_q <= cnt_q - CNT_ONE;
                end
            end
        end
    end

    always_comb begin
        evt           = '0;
        evt.fire      = tick && at_zero;
        evt.hold_high = below_limit(64'(active_n_q), SMALL_LIM);
    end

    // R2: counter never above the value loaded last
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= active_n_q);
    // R2: ticks come at most every other cycle
    a_r2_tick_alt: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart) |=> !tick);
    // R2: a tick on a nonzero count decrements by one
    a_r2_dec: assert property (@(posedge clk) disable iff (rst)
        (tick && !at_zero && !restart) |=> (cnt_q == $past(cnt_q) - CNT_ONE));
    // R4: a reload takes the current input value
    a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && at_zero && !restart) |=> (active_n_q == $past(reload_val)));

endmodule

// File: rtl/upd_pulse_stretch.sv
module upd_pulse_stretch
    import upd_pkg::*;
#(
    parameter int unsigned PULSE_LEN = UPD_PULSE_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic start,
    output logic active
);
    localparam int unsigned LEN_W = $clog2(PULSE_LEN + 1);
    localparam logic [LEN_W-1:0] LEN_LOAD = LEN_W'(PULSE_LEN);

    logic [LEN_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LEN_LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - LEN_W'(1);
        end
    end

    assign active = (left_q != '0);

    // R5: a start loads the full length
    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        (start && !clear) |=> (left_q == LEN_LOAD));
    // R5: remaining count never exceeds the pulse length
    a_r5_bound: assert property (@(posedge clk) disable iff (rst)
        left_q <= LEN_LOAD);
    // R10: clear cancels the pulse
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        clear |=> !active);

endmodule

// File: rtl/upd_edge_sync.sv
module upd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] && !last_q;

    // R7: a detected edge is never two cycles wide
    a_r7_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/upd_clk_gen.sv
module upd_clk_gen
    import upd_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned PULSE_LEN   = UPD_PULSE_CYCLES,
    parameter int unsigned SMALL_LIM   = UPD_SMALL_LIMIT,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_int,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             ext_in,
    output logic             upd_strobe,
    output logic             pin_out,
    output logic             pin_oe
);
    upd_src_e mode_q;
    upd_src_e mode_req;
    logic     restart;
    logic     run_int;
    int_evt_t evt;
    logic     ext_rise;
    logic     stretch_on;
    logic     strobe_q;

    assign mode_req = mode_int ? UPD_SRC_INT : UPD_SRC_EXT;
    assign restart  = (mode_req != mode_q);
    assign run_int  = (mode_q == UPD_SRC_INT) && !restart;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= UPD_SRC_INT;
        else     mode_q <= mode_req;
    end

    upd_cnt_core #(
        .CNT_W     (CNT_W),
        .SMALL_LIM (SMALL_LIM)
    ) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .run        (run_int),
        .reload_val (reload_val),
        .evt        (evt)
    );

    upd_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_in),
        .rise     (ext_rise)
    );

    upd_pulse_stretch #(
        .PULSE_LEN (PULSE_LEN)
    ) stretch_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (restart),
        .start  (run_int && evt.fire),
        .active (stretch_on)
    );

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            strobe_q <= 1'b0;
        end else if (mode_q == UPD_SRC_INT) begin
            strobe_q <= evt.fire;
        end else begin
            strobe_q <= ext_rise;
        end
    end

    assign upd_strobe = strobe_q;
    assign pin_oe     = (mode_q == UPD_SRC_INT);
    assign pin_out    = (mode_q == UPD_SRC_INT) && (evt.hold_high || stretch_on);

    // R9: pin released and low in external mode
    a_r9_ext_released: assert property (@(posedge clk) disable iff (rst)
        (mode_q == UPD_SRC_EXT) |-> (!pin_oe && !pin_out));
    // R5: an internal strobe is visible on the pin
    a_r5_strobe_on_pin: assert property (@(posedge clk) disable iff (rst)
        (upd_strobe && mode_q == UPD_SRC_INT) |-> pin_out);
    // R6: small reload values keep the pin high
    a_r6_hold_high: assert property (@(posedge clk) disable iff (rst)
        (mode_q == UPD_SRC_INT && evt.hold_high) |-> pin_out);
    // R10: no strobe right after a mode change
    a_r10_no_strobe: assert property (@(posedge clk) disable iff (rst)
        restart |=> !upd_strobe);
    // R8: external strobes only follow a synchronized edge
    a_r8_ext_cause: assert property (@(posedge clk) disable iff (rst)
        (mode_q == UPD_SRC_EXT && !restart && !ext_rise) |=> !upd_strobe);

endmodule

// File: tb/upd_clk_gen_tb_top.sv
module upd_clk_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_int;
    logic [31:0] reload_val;
    logic        ext_in;
    logic        upd_strobe;
    logic        pin_out;
    logic        pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    upd_clk_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode_int   (mode_int),
        .reload_val (reload_val),
        .ext_in     (ext_in),
        .upd_strobe (upd_strobe),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    function automatic int exp_period(input int n);
        return 2 * (n + 1);
    endfunction

    function automatic int exp_width(input int n);
        return (n < 5) ? -1 : 8;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            summary();
        end
    end

    // counts negedges until a strobe is seen; returns the count
    task automatic to_strobe(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!upd_strobe && k < 5000);
    endtask

    // called on a strobe sample: measures period to next strobe,
    // pin high run from this strobe, and pin lows in the interval
    task automatic measure(output int per, output int hi, output int lows, output int sw);
        bit run_hi = 1;
        per  = 0;
        hi   = pin_out ? 1 : 0;
        lows = pin_out ? 0 : 1;
        sw   = 0;
        do begin
            @(negedge clk);
            per++;
            if (upd_strobe) sw++;
            if (!pin_out) begin
                lows++;
                run_hi = 0;
            end else if (run_hi) begin
                hi++;
            end
        end while (!upd_strobe && per < 5000);
    endtask

    task automatic do_reset(input int n);
        rst        = 1'b1;
        mode_int   = 1'b1;
        ext_in     = 1'b0;
        reload_val = 32'(n);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int k, per, hi, lows, sw, n, cnt;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1;
        mode_int = 1'b1;
        ext_in = 1'b0;
        reload_val = 32'd7;
        @(negedge clk);

        // R1: reset state
        do_reset(7);
        chk("R1 pin_oe after reset", pin_oe, 1);
        chk("R1 strobe after reset", upd_strobe, 0);
        // R3: first strobe
        to_strobe(k);
        chk("R3 first strobe edge count", k, exp_period(7));
        @(negedge clk);
        chk("R3 strobe one cycle wide", upd_strobe, 0);

        // R2/R5: random reload values
        for (int it = 0; it < 6; it++) begin
            n = 5 + int'($urandom_range(0, 40));
            do_reset(n);
            to_strobe(k);
            chk("R3 first strobe random N", k, exp_period(n));
            measure(per, hi, lows, sw);
            chk("R2 period random N", per, exp_period(n));
            chk("R5 pin high width", hi, exp_width(n));
        end

        // R5 boundary N=5
        do_reset(5);
        to_strobe(k);
        measure(per, hi, lows, sw);
        chk("R2 period N=5", per, exp_period(5));
        chk("R5 width N=5", hi, 8);

        // R6: small N keeps pin high, strobes continue
        for (int s = 1; s < 5; s++) begin
            do_reset(s);
            chk("R6 pin high right after reset", pin_out, 1);
            to_strobe(k);
            chk("R6 first strobe small N", k, exp_period(s));
            measure(per, hi, lows, sw);
            chk("R6 period small N", per, exp_period(s));
            chk("R6 pin never low", lows, 0);
        end

        // R4: change of N applies from the next reload
        do_reset(20);
        to_strobe(k);
        repeat (3) @(negedge clk);
        reload_val = 32'd9;
        to_strobe(k);
        chk("R4 running period unchanged", k + 3, exp_period(20));
        measure(per, hi, lows, sw);
        chk("R4 next period uses new N", per, exp_period(9));

        // R9/R8: external mode, idle
        mode_int = 1'b0;
        @(negedge clk);
        chk("R9 pin_oe low in external", pin_oe, 0);
        chk("R9 pin_out low in external", pin_out, 0);
        cnt = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (upd_strobe) cnt++;
        end
        chk("R8 no strobes while idle in external", cnt, 0);

        // R7: latency and width
        ext_in = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!upd_strobe && k < 50);
        chk("R7 edge latency", k, 3);
        @(negedge clk);
        chk("R7 strobe one cycle", upd_strobe, 0);
        // R8: held high and falling edge
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (upd_strobe) cnt++;
        end
        chk("R8 held high no strobe", cnt, 0);
        ext_in = 1'b0;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (upd_strobe) cnt++;
        end
        chk("R8 falling edge no strobe", cnt, 0);

        // R7: random edge train
        cnt = 0;
        for (int e = 0; e < 8; e++) begin
            ext_in = 1'b1;
            repeat (4 + $urandom_range(0, 6)) begin
                @(negedge clk);
                if (upd_strobe) cnt++;
            end
            ext_in = 1'b0;
            repeat (4 + $urandom_range(0, 6)) begin
                @(negedge clk);
                if (upd_strobe) cnt++;
            end
        end
        repeat (5) begin
            @(negedge clk);
            if (upd_strobe) cnt++;
        end
        chk("R7 one strobe per rising edge", cnt, 8);

        // R10: entering internal restarts the count
        reload_val = 32'd10;
        mode_int = 1'b1;
        to_strobe(k);
        chk("R10 first strobe after mode entry", k, exp_period(10) + 1);
        chk("R1 pin_oe back in internal", pin_oe, 1);
        // R10: switch away mid-pulse clears the pin
        repeat (2) @(negedge clk);
        chk("R5 pin still high mid-pulse", pin_out, 1);
        mode_int = 1'b0;
        @(negedge clk);
        chk("R10 pin cleared after switch", pin_out, 0);
        chk("R9 pin_oe cleared after switch", pin_oe, 0);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (upd_strobe) cnt++;
        end
        chk("R8 counter silent in external", cnt, 0);

        summary();
    end

endmodule